// File: doc/BRIEF.md
# Processor Run/Stop Power Controller

This block starts and halts a cluster of virtual processors (VPs) under software control. A small register bus carries address, write enable and 64-bit write data in, and returns 64-bit read data. Writing a VP mask to the run register starts every selected VP that is idle. The controller sends that VP a one-cycle reset pulse and waits for the VP's reset-done acknowledge before it marks the VP as running. Writing a mask to the stop register halts every selected VP that is running. The controller sends a one-cycle halt pulse and clears the running bit at once.

The running vector can be read at the status register. All three registers appear in two address windows: a cluster-wide window at base 0x0000 and a core-local window at base 0x2000. Inside each window, run is at +0x00, stop at +0x08 and status at +0x10. Any other address reads as zero. A write to any other address changes nothing and raises `unimpl_wr` for that cycle.

After reset, the VPs named by the `BOOT_MASK` parameter are started through the same handshake that a run write uses.

Top module: `vp_run_ctrl`

## Requirements
- R1: Only the low `NUM_VP` bits of a run or stop write are used; higher data bits have no effect on any output.
- R2: A run write starts only the selected VPs that are neither running nor awaiting reset-done; for all other VPs it produces no reset pulse and no status change.
- R3: Starting a VP drives its bit of `vp_rst_req` high for exactly one cycle, the cycle after the write is sampled; its status bit stays 0 at that point.
- R4: A VP awaiting reset-done becomes running at the clock edge that samples its `vp_rst_done` bit high; `vp_rst_done` has no effect on a VP that is not awaiting it.
- R5: A stop write makes each selected running VP raise `vp_halt_req` for exactly one cycle, the cycle after the write; its status bit clears on that same edge; selected VPs that are not running get no halt pulse.
- R6: A stop write for a VP that is awaiting reset-done cancels the start: no halt pulse, and a later `vp_rst_done` leaves its status bit at 0.
- R7: A read at status (+0x10) returns the running vector in bits [NUM_VP-1:0], with bit i meaning VP i, and zeros above; `rdata` follows the address in the same cycle.
- R8: Run (0x0000/0x2000), stop (0x0008/0x2008) and status (0x0010/0x2010) act identically in both windows.
- R9: Any other address reads as 0; a write there changes no state and asserts `unimpl_wr` combinationally in the same cycle.
- R10: Reset clears the running vector; on the first clock edge after reset is released, the VPs in `BOOT_MASK` start through the R3/R4 handshake. A `BOOT_MASK` with bits at or above `NUM_VP` is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr | input | 1 | Write enable, sampled on the rising edge |
| bus_wdata | input | 64 | Write data (VP mask) |
| bus_rdata | output | 64 | Read data, combinational from the address |
| unimpl_wr | output | 1 | Write to an unimplemented address this cycle |
| vp_rst_req | output | NUM_VP | One-cycle reset pulse per VP |
| vp_halt_req | output | NUM_VP | One-cycle halt pulse per VP |
| vp_rst_done | input | NUM_VP | Reset-done acknowledge per VP |

## Verification
`bus_rdata` and `unimpl_wr` are due in the same cycle as the address. Reset and halt pulses, and a cleared status bit after a stop, are due one cycle after the write edge. A set status bit is due one cycle after the edge that samples `vp_rst_done`. Inputs change on the falling edge. All outputs are compared 2 ns later against a behavioural model that is updated on each rising edge, so every comparison falls inside the cycle in which its result is due. Directed reads at these same points check the status values that the requirements name.

// File: rtl/vprc_pkg.sv
package vprc_pkg;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_RUN  = 2'd1,
    SEL_STOP = 2'd2,
    SEL_STAT = 2'd3
  } vprc_sel_e;

  localparam logic [31:0] WIN_CORE = 32'h0000_2000;
  localparam logic [31:0] OFF_RUN  = 32'h0000_0000;
  localparam logic [31:0] OFF_STOP = 32'h0000_0008;
  localparam logic [31:0] OFF_STAT = 32'h0000_0010;

  // Mask of the implemented VP bits for a given VP count.
  function automatic logic [63:0] valid_vp_mask(input int unsigned n);
    logic [63:0] m;
    m = '0;
    for (int i = 0; i < 64; i++) begin
      if (i < n) m[i] = 1'b1;
    end
    return m;
  endfunction

  // Folds both windows onto one offset and classifies the address.
  function automatic vprc_sel_e classify(input logic [31:0] a);
    logic [31:0] off;
    off = a & ~WIN_CORE;
    case (off)
      OFF_RUN:  return SEL_RUN;
      OFF_STOP: return SEL_STOP;
      OFF_STAT: return SEL_STAT;
      default:  return SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/vprc_decode.sv
module vprc_decode #(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  output logic              run_wr,
  output logic              stop_wr,
  output logic              stat_sel,
  output logic              bad_wr
);
  import vprc_pkg::*;

  vprc_sel_e sel;
  logic [31:0] addr_ext;

  assign addr_ext = 32'(addr);
  assign sel      = classify(addr_ext);
  assign run_wr   = wr && (sel == SEL_RUN);
  assign stop_wr  = wr && (sel == SEL_STOP);
  assign stat_sel = (sel == SEL_STAT);
  assign bad_wr   = wr && (sel == SEL_NONE);
endmodule

// File: rtl/vprc_slot.sv
module vprc_slot (
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic stop_req,
  input  logic rst_done,
  output logic rst_pulse,
  output logic halt_pulse,
  output logic running,
  output logic pending
);
  logic run_q, pend_q, rp_q, hp_q;
  logic start_go;

  assign start_go = start_req && !run_q && !pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      pend_q <= 1'b0;
      rp_q   <= 1'b0;
      hp_q   <= 1'b0;
    end else begin
      rp_q <= start_go && !stop_req;
      hp_q <= stop_req && run_q;
      if (stop_req) begin
        run_q  <= 1'b0;
        pend_q <= 1'b0;
      end else if (start_go) begin
        pend_q <= 1'b1;
      end else if (pend_q && rst_done) begin
        pend_q <= 1'b0;
        run_q  <= 1'b1;
      end
    end
  end

  assign rst_pulse  = rp_q;
  assign halt_pulse = hp_q;
  assign running    = run_q;
  assign pending    = pend_q;
endmodule

// File: rtl/vp_run_ctrl.sv
module vp_run_ctrl #(
  parameter int          NUM_VP    = 1,
  parameter int          ADDR_W    = 16,
  parameter logic [63:0] BOOT_MASK = 64'h1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [63:0]       bus_wdata,
  output logic [63:0]       bus_rdata,
  output logic              unimpl_wr,
  output logic [NUM_VP-1:0] vp_rst_req,
  output logic [NUM_VP-1:0] vp_halt_req,
  input  logic [NUM_VP-1:0] vp_rst_done
);
  import vprc_pkg::*;

  localparam logic [63:0] VALID = valid_vp_mask(NUM_VP);

  if ((BOOT_MASK & ~VALID) != 64'h0) begin : g_bad_boot
    $error("BOOT_MASK selects VPs beyond NUM_VP");
  end

  logic run_wr, stop_wr, stat_sel;
  logic boot_armed;
  logic [63:0] run_sel, stop_sel;
  logic [NUM_VP-1:0] running_vec, pending_vec;

  vprc_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr     (bus_addr),
    .wr       (bus_wr),
    .run_wr   (run_wr),
    .stop_wr  (stop_wr),
    .stat_sel (stat_sel),
    .bad_wr   (unimpl_wr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) boot_armed <= 1'b1;
    else        boot_armed <= 1'b0;
  end

  assign run_sel  = ((run_wr ? bus_wdata : 64'h0) | (boot_armed ? BOOT_MASK : 64'h0)) & VALID;
  assign stop_sel = (stop_wr ? bus_wdata : 64'h0) & VALID;

  for (genvar g = 0; g < NUM_VP; g++) begin : g_vp
    vprc_slot u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_req  (run_sel[g]),
      .stop_req   (stop_sel[g]),
      .rst_done   (vp_rst_done[g]),
      .rst_pulse  (vp_rst_req[g]),
      .halt_pulse (vp_halt_req[g]),
      .running    (running_vec[g]),
      .pending    (pending_vec[g])
    );
  end

  assign bus_rdata = stat_sel ? 64'(running_vec) : 64'h0;
endmodule

// File: rtl/vprc_checker.sv
module vprc_checker #(
  parameter int NUM_VP = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_VP-1:0] vp_rst_req,
  input logic [NUM_VP-1:0] vp_halt_req,
  input logic [NUM_VP-1:0] vp_rst_done,
  input logic [NUM_VP-1:0] running,
  input logic [NUM_VP-1:0] pending,
  input logic              stat_sel,
  input logic [63:0]       rdata
);
  assert_rst_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (vp_rst_req & $past(vp_rst_req)) == '0);

  assert_run_needs_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (running & ~$past(running) & ~$past(vp_rst_done & pending)) == '0);

  assert_halt_only_running_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (vp_halt_req & ~$past(running)) == '0);

  assert_halt_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (vp_halt_req & running) == '0);

  assert_cancel_no_halt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pending) & ~pending & ~running & vp_halt_req) == '0);

  assert_unimpl_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_sel |-> (rdata == 64'h0));
endmodule

bind vp_run_ctrl vprc_checker #(.NUM_VP(NUM_VP)) u_vprc_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .vp_rst_req  (vp_rst_req),
  .vp_halt_req (vp_halt_req),
  .vp_rst_done (vp_rst_done),
  .running     (running_vec),
  .pending     (pending_vec),
  .stat_sel    (stat_sel),
  .rdata       (bus_rdata)
);

// File: tb/tb_vp_run_ctrl.sv
module tb_vp_run_ctrl;
  localparam int NV = 4;
  localparam logic [3:0] BOOT = 4'b0011;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        wr = 1'b0;
  logic [63:0] wdata = '0;
  logic [3:0]  done = '0;
  logic [63:0] rdata;
  logic        unimpl;
  logic [3:0]  rstp, haltp;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  vp_run_ctrl #(.NUM_VP(NV), .ADDR_W(16), .BOOT_MASK(64'(BOOT))) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata),
    .bus_rdata(rdata), .unimpl_wr(unimpl), .vp_rst_req(rstp),
    .vp_halt_req(haltp), .vp_rst_done(done)
  );

  function automatic bit at_run(input logic [15:0] a);  return a == 16'h0000 || a == 16'h2000; endfunction
  function automatic bit at_stop(input logic [15:0] a); return a == 16'h0008 || a == 16'h2008; endfunction
  function automatic bit at_stat(input logic [15:0] a); return a == 16'h0010 || a == 16'h2010; endfunction

  // Behavioural reference model
  logic [3:0] m_run = '0, m_pend = '0, m_rp = '0, m_hp = '0;
  bit m_armed = 1;

  always @(posedge clk) begin : model
    logic [3:0] rq, sq, go;
    if (!rst_n) begin
      m_run = '0; m_pend = '0; m_rp = '0; m_hp = '0; m_armed = 1;
    end else begin
      rq = (m_armed ? BOOT : 4'h0) | ((wr && at_run(addr)) ? wdata[3:0] : 4'h0);
      sq = (wr && at_stop(addr)) ? wdata[3:0] : 4'h0;
      go = rq & ~m_run & ~m_pend;
      m_hp = sq & m_run;
      m_rp = go & ~sq;
      m_run = (m_run | (done & m_pend)) & ~sq;
      m_pend = ((m_pend & ~done) | go) & ~sq;
      m_armed = 0;
    end
  end

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (!finished) begin
      chk(rdata, at_stat(addr) ? 64'(m_run) : 64'h0, "R7 rdata vs model");
      chk(64'(rstp), 64'(m_rp), "R3 vp_rst_req vs model");
      chk(64'(haltp), 64'(m_hp), "R5 vp_halt_req vs model");
      chk(64'(unimpl), 64'(wr && !at_run(addr) && !at_stop(addr) && !at_stat(addr)), "R9 unimpl_wr vs model");
    end
  end

  task automatic step(input logic [15:0] a, input logic w, input logic [63:0] d, input logic [3:0] dn);
    @(negedge clk);
    addr = a; wr = w; wdata = d; done = dn;
  endtask

  task automatic idle(); step(16'h0000, 1'b0, 64'h0, 4'h0); endtask

  task automatic peek(input logic [15:0] a, input logic [63:0] exp, input string tag);
    step(a, 1'b0, 64'h0, 4'h0);
    #3;
    chk(rdata, exp, tag);
  endtask

  initial begin
    repeat (3) idle();
    peek(16'h0010, 64'h0, "R10 status in reset");
    @(negedge clk); rst_n = 1'b1;
    idle(); #3; chk(64'(rstp), 64'h3, "R10 boot reset pulses");
    peek(16'h0010, 64'h0, "R3 boot not yet running");
    step(16'h0000, 1'b0, 64'h0, 4'b0001);
    peek(16'h0010, 64'h1, "R4 VP0 running after done");
    step(16'h0000, 1'b0, 64'h0, 4'b0010);
    peek(16'h2010, 64'h3, "R8 status via core window");
    step(16'h0000, 1'b1, 64'hFFFF_FFFF_FFFF_FFFC, 4'h0);
    idle(); #3; chk(64'(rstp), 64'hC, "R1 only VP2,VP3 pulsed");
    peek(16'h0010, 64'h3, "R3 status unchanged on pulse");
    step(16'h0000, 1'b0, 64'h0, 4'b0100);
    step(16'h2008, 1'b1, 64'h8, 4'h0);
    idle(); #3; chk(64'(haltp), 64'h0, "R6 no halt for pending");
    step(16'h0000, 1'b0, 64'h0, 4'b1000);
    peek(16'h0010, 64'h7, "R6 cancelled VP3 stays clear");
    step(16'h2000, 1'b1, 64'h1, 4'h0);
    idle(); #3; chk(64'(rstp), 64'h0, "R2 running VP0 ignored");
    step(16'h0008, 1'b1, 64'h5, 4'h0);
    idle(); #3; chk(64'(haltp), 64'h5, "R5 halt VP0,VP2");
    peek(16'h0010, 64'h2, "R5 status cleared");
    step(16'h0018, 1'b1, 64'hF, 4'h0); #3; chk(64'(unimpl), 64'h1, "R9 unimpl write flagged");
    peek(16'h0018, 64'h0, "R9 unimpl read zero");
    peek(16'h4010, 64'h0, "R9 out-of-window read zero");
    peek(16'h0010, 64'h2, "R9 state unchanged");
    step(16'h0000, 1'b0, 64'h0, 4'hF);
    peek(16'h0010, 64'h2, "R4 stray done ignored");
    step(16'h2000, 1'b1, 64'h1, 4'h0);
    idle(); #3; chk(64'(rstp), 64'h1, "R8 run via core window");
    step(16'h0000, 1'b0, 64'h0, 4'b0001);
    peek(16'h2010, 64'h3, "R8 VP0 restarted");
    idle();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule